// File: doc/BRIEF.md
# Automatic transmit/receive pin switcher

This block sits between the software-visible output registers of four daughterboard I/O banks and the pins themselves. Each bank carries sixteen general-purpose outputs. For every bit that a per-bank selection mask marks, the driven level is not the bank's ordinary output value. It is taken from one of two per-bank patterns instead: a transmit pattern or a receive pattern. The choice between them follows whether the transmit FIFO currently holds data. Bits left out of the mask pass the ordinary output value straight through.

An internal transmit/receive state decides which pattern is shown. It follows the FIFO-nonempty flag, but each direction of change can be held back by its own programmable number of clock ticks. Both of these delays are shared by all banks. A flag that reverts before its delay runs out leaves the state untouched. A global enable input switches the whole mechanism on or off. When it is low, every pin shows its ordinary output value.

Registers are loaded through a one-cycle write strobe with a 7-bit address and a 32-bit data word. Reset is asynchronous and active-low, and its release is synchronised inside the block.

Top module: `atr_switch`

## Requirements
- R1: After reset, every register (masks, patterns, both delays) is 0 and the T/R state is receive, so `gpio_out` equals `gpio_normal` even with `atr_enable` and `txq_nonempty` high.
- R2: A write with `wr_en` high stores `wr_data[15:0]` into the mask of bank b at address 0x20+b, the transmit pattern of bank b at 0x28+b, and the receive pattern of bank b at 0x30+b (b = 0..3). It stores `wr_data[11:0]` into the enter-transmit delay at 0x38 and the return-to-receive delay at 0x39. Higher data bits and all other addresses have no effect.
- R3: With `atr_enable` high, output bit i of bank b (`gpio_out[16*b+i]`) comes from the selected pattern where mask bit i is 1, and from `gpio_normal[16*b+i]` where it is 0.
- R4: Masked bits show the transmit pattern while the T/R state is transmit, and the receive pattern while it is receive.
- R5: With `atr_enable` low, `gpio_out` equals `gpio_normal` on every bit, whatever the masks and the T/R state.
- R6: With enter-transmit delay N, the T/R state becomes transmit at the (N+1)-th rising clock edge at which `txq_nonempty` has been continuously 1 while the state was receive. N = 0 switches at the first such edge.
- R7: With return-to-receive delay M, the T/R state becomes receive at the (M+1)-th rising edge at which `txq_nonempty` has been continuously 0 while the state was transmit.
- R8: If `txq_nonempty` returns to the current T/R state before the pending delay expires, the count is discarded and the state does not change. A later change of the flag starts a fresh count.
- R9: `gpio_out` responds to `gpio_normal` and `atr_enable` in the same cycle. A register write becomes visible on `gpio_out` in the cycle after its strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Single-cycle register write strobe |
| wr_addr | input | 7 | Register write address |
| wr_data | input | 32 | Register write data |
| atr_enable | input | 1 | Global enable of pattern switching |
| txq_nonempty | input | 1 | Transmit FIFO holds data |
| gpio_normal | input | 64 | Ordinary output value of the four banks, bank b at bits 16*b+15:16*b |
| gpio_out | output | 64 | Merged output value of the four banks, same packing |

## Verification
A wrong T/R state shows up at once on every masked bit of every bank: all of them carry the wrong pattern in that very cycle. A delay counter that is off by one therefore makes the switch one cycle early or late, and a broken cancel makes a short FIFO pulse flip the pins. A corrupted mask or pattern register shows the wrong source or value on its bits from the cycle after the write. For this reason the bench runs a behavioural model alongside the design and compares the full 64-bit output on every clock. This covers short pulses, pulses exactly one tick long enough, zero and maximum delays, and writes to unused addresses.

// File: rtl/atr_pkg.sv
package atr_pkg;
  // Register address bases; bank b adds b to the base (room for 8 banks).
  localparam int unsigned ADDR_MASK_BASE = 32'h20;
  localparam int unsigned ADDR_TXV_BASE  = 32'h28;
  localparam int unsigned ADDR_RXV_BASE  = 32'h30;
  localparam int unsigned ADDR_RISE_DLY  = 32'h38;
  localparam int unsigned ADDR_FALL_DLY  = 32'h39;
  localparam int unsigned MAX_BANKS      = 8;

  typedef enum logic {
    TR_RECEIVE  = 1'b0,
    TR_TRANSMIT = 1'b1
  } tr_state_e;
endpackage

// File: rtl/atr_rst_sync.sv
module atr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_async,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_async) begin
    if (!rst_n_async) sync_q <= '0;
    else              sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/atr_regfile.sv
module atr_regfile
  import atr_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int PIN_W     = 16,
  parameter int DLY_W     = 12,
  parameter int ADDR_W    = 7,
  parameter int DATA_W    = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [ADDR_W-1:0]          wr_addr,
  input  logic [DATA_W-1:0]          wr_data,
  output logic [NUM_BANKS*PIN_W-1:0] mask_flat,
  output logic [NUM_BANKS*PIN_W-1:0] txv_flat,
  output logic [NUM_BANKS*PIN_W-1:0] rxv_flat,
  output logic [DLY_W-1:0]           rise_dly,
  output logic [DLY_W-1:0]           fall_dly
);
  logic unused_hi;
  assign unused_hi = ^wr_data[DATA_W-1:PIN_W];

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic             hit_mask, hit_txv, hit_rxv;
    logic [PIN_W-1:0] mask_q, txv_q, rxv_q;

    always_comb begin
      hit_mask = wr_en && (wr_addr == ADDR_W'(ADDR_MASK_BASE + b));
      hit_txv  = wr_en && (wr_addr == ADDR_W'(ADDR_TXV_BASE + b));
      hit_rxv  = wr_en && (wr_addr == ADDR_W'(ADDR_RXV_BASE + b));
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mask_q <= '0;
        txv_q  <= '0;
        rxv_q  <= '0;
      end else begin
        if (hit_mask) mask_q <= wr_data[PIN_W-1:0];
        if (hit_txv)  txv_q  <= wr_data[PIN_W-1:0];
        if (hit_rxv)  rxv_q  <= wr_data[PIN_W-1:0];
      end
    end

    assign mask_flat[b*PIN_W +: PIN_W] = mask_q;
    assign txv_flat[b*PIN_W +: PIN_W]  = txv_q;
    assign rxv_flat[b*PIN_W +: PIN_W]  = rxv_q;
  end

  logic hit_rise, hit_fall;
  logic [DLY_W-1:0] rise_q, fall_q;

  always_comb begin
    hit_rise = wr_en && (wr_addr == ADDR_W'(ADDR_RISE_DLY));
    hit_fall = wr_en && (wr_addr == ADDR_W'(ADDR_FALL_DLY));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rise_q <= '0;
      fall_q <= '0;
    end else begin
      if (hit_rise) rise_q <= wr_data[DLY_W-1:0];
      if (hit_fall) fall_q <= wr_data[DLY_W-1:0];
    end
  end

  assign rise_dly = rise_q;
  assign fall_dly = fall_q;
endmodule

// File: rtl/atr_tr_timer.sv
module atr_tr_timer
  import atr_pkg::*;
#(
  parameter int DLY_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             txq_nonempty,
  input  logic [DLY_W-1:0] rise_dly,
  input  logic [DLY_W-1:0] fall_dly,
  output logic             tr_transmit
);
  tr_state_e        state_q, state_d;
  logic [DLY_W-1:0] cnt_q, cnt_d;
  logic [DLY_W-1:0] active_dly;
  logic             pending;

  always_comb begin
    state_d    = state_q;
    cnt_d      = '0;
    pending    = (txq_nonempty != logic'(state_q));
    active_dly = (state_q == TR_TRANSMIT) ? fall_dly : rise_dly;
    if (pending) begin
      if (cnt_q >= active_dly) begin
        state_d = tr_state_e'(txq_nonempty);
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= TR_RECEIVE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign tr_transmit = (state_q == TR_TRANSMIT);
endmodule

// File: rtl/atr_bank_mux.sv
module atr_bank_mux #(
  parameter int PIN_W = 16
) (
  input  logic             enable,
  input  logic             tr_transmit,
  input  logic [PIN_W-1:0] mask,
  input  logic [PIN_W-1:0] txv,
  input  logic [PIN_W-1:0] rxv,
  input  logic [PIN_W-1:0] normal,
  output logic [PIN_W-1:0] pins
);
  logic [PIN_W-1:0] pattern;

  always_comb begin
    pattern = tr_transmit ? txv : rxv;
    if (enable) pins = (pattern & mask) | (normal & ~mask);
    else        pins = normal;
  end
endmodule

// File: rtl/atr_switch.sv
module atr_switch
  import atr_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int PIN_W     = 16,
  parameter int DLY_W     = 12,
  parameter int ADDR_W    = 7,
  parameter int DATA_W    = 32,
  localparam int BUS_W    = NUM_BANKS * PIN_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              atr_enable,
  input  logic              txq_nonempty,
  input  logic [BUS_W-1:0]  gpio_normal,
  output logic [BUS_W-1:0]  gpio_out
);
  logic             rst_n_sync;
  logic [BUS_W-1:0] mask_flat, txv_flat, rxv_flat;
  logic [DLY_W-1:0] rise_dly, fall_dly;
  logic             tr_transmit;

  atr_rst_sync #(.STAGES(2)) rst_sync_i (
    .clk        (clk),
    .rst_n_async(rst_n),
    .rst_n_sync (rst_n_sync)
  );

  atr_regfile #(
    .NUM_BANKS(NUM_BANKS), .PIN_W(PIN_W), .DLY_W(DLY_W),
    .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) regs_i (
    .clk      (clk),
    .rst_n    (rst_n_sync),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .mask_flat(mask_flat),
    .txv_flat (txv_flat),
    .rxv_flat (rxv_flat),
    .rise_dly (rise_dly),
    .fall_dly (fall_dly)
  );

  atr_tr_timer #(.DLY_W(DLY_W)) timer_i (
    .clk         (clk),
    .rst_n       (rst_n_sync),
    .txq_nonempty(txq_nonempty),
    .rise_dly    (rise_dly),
    .fall_dly    (fall_dly),
    .tr_transmit (tr_transmit)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_mux
    atr_bank_mux #(.PIN_W(PIN_W)) mux_i (
      .enable     (atr_enable),
      .tr_transmit(tr_transmit),
      .mask       (mask_flat[b*PIN_W +: PIN_W]),
      .txv        (txv_flat[b*PIN_W +: PIN_W]),
      .rxv        (rxv_flat[b*PIN_W +: PIN_W]),
      .normal     (gpio_normal[b*PIN_W +: PIN_W]),
      .pins       (gpio_out[b*PIN_W +: PIN_W])
    );
  end
endmodule

// File: rtl/atr_switch_chk.sv
module atr_switch_chk
  import atr_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int PIN_W     = 16,
  parameter int DLY_W     = 12,
  parameter int ADDR_W    = 7,
  parameter int DATA_W    = 32,
  localparam int BUS_W    = NUM_BANKS * PIN_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic              atr_enable,
  input logic              txq_nonempty,
  input logic [BUS_W-1:0]  gpio_normal,
  input logic [BUS_W-1:0]  gpio_out,
  input logic [BUS_W-1:0]  mask_flat,
  input logic              tr_transmit,
  input logic [DLY_W-1:0]  rise_dly,
  input logic [DLY_W-1:0]  fall_dly
);
  a_r5_disabled_passthru: assert property (@(posedge clk) disable iff (!rst_n)
    !atr_enable |-> (gpio_out == gpio_normal));

  a_r3_unmasked_from_normal: assert property (@(posedge clk) disable iff (!rst_n)
    (((gpio_out ^ gpio_normal) & ~mask_flat) == '0));

  a_r6_zero_rise_next: assert property (@(posedge clk) disable iff (!rst_n)
    (!tr_transmit && txq_nonempty && rise_dly == '0) |=> tr_transmit);

  a_r7_zero_fall_next: assert property (@(posedge clk) disable iff (!rst_n)
    (tr_transmit && !txq_nonempty && fall_dly == '0) |=> !tr_transmit);

  a_r8_hold_receive: assert property (@(posedge clk) disable iff (!rst_n)
    (!tr_transmit && !txq_nonempty) |=> !tr_transmit);

  a_r8_hold_transmit: assert property (@(posedge clk) disable iff (!rst_n)
    (tr_transmit && txq_nonempty) |=> tr_transmit);

  a_r2_mask0_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == ADDR_W'(ADDR_MASK_BASE)) |=>
      (mask_flat[PIN_W-1:0] == $past(wr_data[PIN_W-1:0])));
endmodule

bind atr_switch atr_switch_chk #(
  .NUM_BANKS(NUM_BANKS), .PIN_W(PIN_W), .DLY_W(DLY_W),
  .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) chk_i (
  .clk         (clk),
  .rst_n       (rst_n_sync),
  .wr_en       (wr_en),
  .wr_addr     (wr_addr),
  .wr_data     (wr_data),
  .atr_enable  (atr_enable),
  .txq_nonempty(txq_nonempty),
  .gpio_normal (gpio_normal),
  .gpio_out    (gpio_out),
  .mask_flat   (mask_flat),
  .tr_transmit (tr_transmit),
  .rise_dly    (rise_dly),
  .fall_dly    (fall_dly)
);

// File: tb/atr_switch_tb.sv
`timescale 1ns/1ps
module atr_switch_tb_top;
  localparam int NB = 4;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [6:0]  wr_addr;
  logic [31:0] wr_data;
  logic        atr_enable;
  logic        txq_nonempty;
  logic [63:0] gpio_normal;
  logic [63:0] gpio_out;

  always #2 clk = ~clk;

  atr_switch dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .atr_enable(atr_enable), .txq_nonempty(txq_nonempty),
    .gpio_normal(gpio_normal), .gpio_out(gpio_out)
  );

  int    total = 0;
  int    bad   = 0;
  bit    done  = 0;
  bit    cmp_on = 0;
  string cur_req = "R1";

  // behavioural reference model
  int m_mask[NB];
  int m_tx[NB];
  int m_rx[NB];
  int m_rise = 0;
  int m_fall = 0;
  int m_run  = 0;
  bit m_tx_state = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int b = 0; b < NB; b++) begin m_mask[b] = 0; m_tx[b] = 0; m_rx[b] = 0; end
      m_rise = 0; m_fall = 0; m_run = 0; m_tx_state = 0;
    end else begin
      int lim;
      if (txq_nonempty != m_tx_state) begin
        m_run = m_run + 1;
        lim = m_tx_state ? m_fall : m_rise;
        if (m_run > lim) begin
          m_tx_state = txq_nonempty;
          m_run = 0;
        end
      end else begin
        m_run = 0;
      end
      if (wr_en) begin
        int a;
        a = int'(wr_addr);
        if (a >= 'h20 && a < 'h20 + NB) m_mask[a - 'h20] = int'(wr_data[15:0]);
        if (a >= 'h28 && a < 'h28 + NB) m_tx[a - 'h28]   = int'(wr_data[15:0]);
        if (a >= 'h30 && a < 'h30 + NB) m_rx[a - 'h30]   = int'(wr_data[15:0]);
        if (a == 'h38) m_rise = int'(wr_data[11:0]);
        if (a == 'h39) m_fall = int'(wr_data[11:0]);
      end
    end
  end

  function automatic logic [63:0] model_out();
    logic [63:0] r;
    for (int b = 0; b < NB; b++) begin
      for (int i = 0; i < 16; i++) begin
        bit sel, pat;
        sel = m_mask[b][i];
        pat = m_tx_state ? m_tx[b][i] : m_rx[b][i];
        r[b*16+i] = (atr_enable && sel) ? pat : gpio_normal[b*16+i];
      end
    end
    return r;
  endfunction

  always @(negedge clk) begin
    if (cmp_on && !done) begin
      logic [63:0] e;
      e = model_out();
      total++;
      if (gpio_out !== e) begin
        bad++;
        $display("FAIL %s at %0t: got=%h exp=%h", cur_req, $time, gpio_out, e);
      end
    end
  end

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic run(input int n);
    repeat (n) tick();
  endtask

  task automatic reg_write(input logic [6:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    tick();
    wr_en = 1'b0; wr_addr = '0; wr_data = '0;
  endtask

  task automatic direct_check(input string req, input logic [63:0] exp);
    total++;
    if (gpio_out !== exp) begin
      bad++;
      $display("FAIL %s direct: got=%h exp=%h", req, gpio_out, exp);
    end
  endtask

  task automatic fifo_pulse(input bit lvl, input int n);
    txq_nonempty = lvl;
    run(n);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      done = 1;
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    atr_enable = 1'b1; txq_nonempty = 1'b0;
    gpio_normal = 64'h0123_4567_89AB_CDEF;
    cmp_on = 1;
    // R1: reset state passes normal values through
    cur_req = "R1";
    run(5);
    rst_n = 1'b1;
    run(4);
    txq_nonempty = 1'b1;
    run(3);
    direct_check("R1", gpio_normal);
    txq_nonempty = 1'b0;
    run(3);

    // R2: register writes, upper data bits and stray addresses ignored
    cur_req = "R2";
    reg_write(7'h20, 32'hDEAD_00FF);
    reg_write(7'h21, 32'h0000_F0F0);
    reg_write(7'h22, 32'hFFFF_FFFF);
    reg_write(7'h23, 32'h1234_8001);
    reg_write(7'h28, 32'h0000_AAAA);
    reg_write(7'h29, 32'h0000_1111);
    reg_write(7'h2A, 32'hBEEF_C3C3);
    reg_write(7'h2B, 32'h0000_7FFE);
    reg_write(7'h30, 32'h0000_5555);
    reg_write(7'h31, 32'h0000_2222);
    reg_write(7'h32, 32'h0000_3C3C);
    reg_write(7'h33, 32'hFFFF_0000);
    run(2);
    direct_check("R2", {16'h0123 & ~16'h8001, 16'h3C3C, (16'h89AB & ~16'hF0F0) | (16'h2222 & 16'hF0F0), (16'hCDEF & ~16'h00FF) | (16'h5555 & 16'h00FF)} | {16'h0000 & 16'h8001, 48'h0});
    reg_write(7'h00, 32'hFFFF_FFFF);
    reg_write(7'h24, 32'hFFFF_FFFF);
    reg_write(7'h3F, 32'hFFFF_FFFF);
    reg_write(7'h7F, 32'hFFFF_FFFF);
    reg_write(7'h3A, 32'hFFFF_FFFF);
    run(2);

    // R3 and R4: several normal patterns in receive state
    cur_req = "R3";
    gpio_normal = 64'hFFFF_FFFF_FFFF_FFFF; run(2);
    gpio_normal = 64'h0000_0000_0000_0000; run(2);
    gpio_normal = 64'hA5A5_5A5A_F00F_0FF0; run(2);
    // R9: same-cycle response to normal input and enable
    cur_req = "R9";
    gpio_normal = 64'h1357_9BDF_2468_ACE0; #1;
    direct_check("R9", model_out());
    atr_enable = 1'b0; #0.5;
    direct_check("R9", gpio_normal);
    atr_enable = 1'b1;
    run(1);

    // R6/R4: zero rise delay, transmit pattern next clock
    cur_req = "R6";
    reg_write(7'h38, 32'hFFFF_0000);
    fifo_pulse(1, 4);
    cur_req = "R4";
    gpio_normal = 64'h0F0F_0F0F_0F0F_0F0F; run(2);
    // R7: zero fall delay
    cur_req = "R7";
    fifo_pulse(0, 4);

    // R6 with nonzero delay, boundary lengths
    cur_req = "R6";
    reg_write(7'h38, 32'h0000_0005);
    reg_write(7'h39, 32'h0000_0009);
    fifo_pulse(1, 6);
    fifo_pulse(1, 3);
    cur_req = "R7";
    fifo_pulse(0, 10);
    fifo_pulse(0, 3);

    // R8: pulses shorter than the delays are cancelled
    cur_req = "R8";
    fifo_pulse(1, 5);
    fifo_pulse(0, 2);
    fifo_pulse(1, 4);
    fifo_pulse(0, 1);
    fifo_pulse(1, 8);
    fifo_pulse(0, 9);
    fifo_pulse(1, 1);
    fifo_pulse(0, 6);
    fifo_pulse(1, 2);
    fifo_pulse(0, 12);

    // R5: enable low in transmit state
    cur_req = "R5";
    fifo_pulse(1, 8);
    atr_enable = 1'b0; run(3);
    gpio_normal = 64'hCAFE_F00D_0BAD_BEEF; run(3);
    atr_enable = 1'b1; run(2);
    fifo_pulse(0, 12);

    // R6: maximum delay
    cur_req = "R6";
    reg_write(7'h38, 32'h0000_0FFF);
    fifo_pulse(1, 4095);
    fifo_pulse(1, 3);
    cur_req = "R7";
    fifo_pulse(0, 12);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule